// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

This block gathers up to 64 device interrupt sources into one shared raw request vector and hands them to as many as four processors. Each processor has its own mask register. The block keeps a per-processor effective register equal to that mask ANDed with the raw vector. Each processor receives one level-sensitive device-interrupt line, which is high whenever its effective register holds any set bit.

Sources drive per-line post and clear strobes. Software reaches the raw vector, the masks and the effective registers through a single-cycle register port. Only the masks can be written. A write to any other register, a narrower-than-64-bit access, or an access to an unmapped index is refused, and the error line pulses. Read data and the error pulse both appear in the cycle after the request.

Top module: `irq_mask_router`

## Requirements
- R1: A post strobe on source n sets raw bit n, and a clear strobe on source n clears it, both at the next clock edge. Index 0 (byte offset 0x000) reads the raw vector.
- R2: When post and clear strobe the same source in the same cycle, the bit ends up set.
- R3: A clear strobe for a source whose raw bit is already zero leaves the raw vector and every effective register unchanged.
- R4: The mask register of processor c sits at index 1+c (offset 0x40*(1+c)). It is written by a full-size write and returns the written value on read.
- R5: The effective register of processor c sits at index 5+c. It always equals mask c AND raw, and it updates at the same edge as the mask write or raw change that alters it.
- R6: cpuIrq[c] is high exactly while effective register c is nonzero. It changes at the same edge as that register.
- R7: A write to index 0 or to indices 5..8 asserts regErr in the next cycle and changes no register.
- R8: An access with regSize other than 3 (3 = 64-bit; 0, 1 and 2 are narrower) asserts regErr in the next cycle, and a write of that kind changes nothing.
- R9: An access to an index above 8 asserts regErr. Whenever a cycle is not the response to a legal read, regRdata is zero.
- R10: During and after reset, all raw, mask and effective registers are zero, cpuIrq is all low, and regErr is low.
- R11: The register index is the byte offset shifted right by 6. Offset bits 5:0 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPost | input | 64 | Per-source post strobes |
| srcClear | input | 64 | Per-source clear strobes |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte offset within the block |
| regSize | input | 2 | Access size code; 3 = 64-bit |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, one cycle after a legal read |
| regErr | output | 1 | One-cycle pulse after an illegal access |
| cpuIrq | output | 4 | Level device-interrupt line per processor |

## Verification
The hardest situations to reach are those where several updates land on the same edge. Examples are a mask write arriving together with a post or clear on a masked-in source, and a post and a clear hitting one source at once. In both cases the effective register and the interrupt line must reflect the combined outcome. Directed steps drive those coincidences on purpose. A long phase of random mixed strobes and accesses then runs against a behavioural model that is compared on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int MAX_CPU = 4;
  localparam int DATA_W = 64;
  localparam logic [1:0] SIZE_FULL = 2'd3;

  typedef logic [1:0] cpuIdx_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASK,
    SEL_EFF
  } rdSel_e;

  typedef struct packed {
    logic [MAX_CPU-1:0] maskWe;
    rdSel_e             rdSel;
    cpuIdx_t            cpu;
    logic               err;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regSize,
  output ctrlStrobes_t      strobes
);
  localparam int IDX_W = ADDR_W - 6;

  logic [IDX_W-1:0] regIdx;
  assign regIdx = regAddr[ADDR_W-1:6];

  always_comb begin
    strobes = '0;
    strobes.rdSel = SEL_NONE;
    if (regValid) begin
      if (regSize != SIZE_FULL) begin
        strobes.err = 1'b1;
      end else if (regIdx == '0) begin
        if (regWrite) strobes.err = 1'b1;
        else          strobes.rdSel = SEL_RAW;
      end else if (regIdx > IDX_W'(2 * NUM_CPU)) begin
        strobes.err = 1'b1;
      end else begin
        for (int c = 0; c < NUM_CPU; c++) begin
          if (regIdx == IDX_W'(c + 1)) begin
            strobes.cpu = cpuIdx_t'(c);
            if (regWrite) strobes.maskWe[c] = 1'b1;
            else          strobes.rdSel = SEL_MASK;
          end
          if (regIdx == IDX_W'(c + 1 + NUM_CPU)) begin
            strobes.cpu = cpuIdx_t'(c);
            if (regWrite) strobes.err = 1'b1;
            else          strobes.rdSel = SEL_EFF;
          end
        end
      end
    end
  end

  always_comb begin
    assert (!(strobes.err && (strobes.maskWe != '0)))
      else $error("AST_ERR_NO_MASK_WE"); // R7
    assert ($onehot0(strobes.maskWe))
      else $error("AST_ONE_MASK_WE"); // R4
  end
endmodule

// File: rtl/irq_router_datapath.sv
module irq_router_datapath
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPost,
  input  logic [NUM_SRC-1:0] srcClear,
  input  logic [DATA_W-1:0]  regWdata,
  input  ctrlStrobes_t       strobes,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regErr,
  output logic [NUM_CPU-1:0] cpuIrq
);
  logic [NUM_SRC-1:0] rawReg, rawNext;
  logic [NUM_SRC-1:0] maskReg [NUM_CPU];
  logic [NUM_SRC-1:0] maskNext[NUM_CPU];
  logic [NUM_SRC-1:0] effReg  [NUM_CPU];
  logic [NUM_SRC-1:0] effNext [NUM_CPU];
  logic [NUM_CPU-1:0] irqNext;
  logic [DATA_W-1:0]  rdMux;

  // post overrides clear on the same source
  assign rawNext = (rawReg & ~srcClear) | srcPost;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign maskNext[c] = strobes.maskWe[c] ? regWdata[NUM_SRC-1:0] : maskReg[c];
    assign effNext[c]  = maskNext[c] & rawNext;
    assign irqNext[c]  = |effNext[c];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskReg[c] <= '0;
        effReg[c]  <= '0;
      end else begin
        maskReg[c] <= maskNext[c];
        effReg[c]  <= effNext[c];
      end
    end

    AST_EFF_IS_AND: assert property (@(posedge clk) disable iff (!rstN)
      effReg[c] == (maskReg[c] & rawReg)); // R5
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrq[c] == (effReg[c] != '0)); // R6
    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
      strobes.err |=> $stable(maskReg[c])); // R7
  end

  always_comb begin
    rdMux = '0;
    unique case (strobes.rdSel)
      SEL_RAW:  rdMux = DATA_W'(rawReg);
      SEL_MASK: rdMux = DATA_W'(maskReg[strobes.cpu]);
      SEL_EFF:  rdMux = DATA_W'(effReg[strobes.cpu]);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawReg   <= '0;
      cpuIrq   <= '0;
      regRdata <= '0;
      regErr   <= 1'b0;
    end else begin
      rawReg   <= rawNext;
      cpuIrq   <= irqNext;
      regRdata <= rdMux;
      regErr   <= strobes.err;
    end
  end

  AST_POST_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (srcPost != '0) |=> ((rawReg & $past(srcPost)) == $past(srcPost))); // R2
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ((srcClear & ~srcPost) != '0) |=> ((rawReg & $past(srcClear & ~srcPost)) == '0)); // R1
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> (regRdata == '0)); // R9
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPost,
  input  logic [NUM_SRC-1:0] srcClear,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [1:0]         regSize,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regErr,
  output logic [NUM_CPU-1:0] cpuIrq
);
  ctrlStrobes_t strobes;

  irq_router_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .regSize (regSize),
    .strobes (strobes)
  );

  irq_router_datapath #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcPost (srcPost),
    .srcClear(srcClear),
    .regWdata(regWdata),
    .strobes (strobes),
    .regRdata(regRdata),
    .regErr  (regErr),
    .cpuIrq  (cpuIrq)
  );

  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regSize != SIZE_FULL) |=> regErr); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (cpuIrq == '0 && !regErr)); // R10
endmodule

// File: tb/sim_irq_mask_router.sv
module sim_irq_mask_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcPost = '0, srcClear = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [1:0]  regSize = 2'd3;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        regErr;
  logic [3:0]  cpuIrq;

  int checks = 0;
  int errors = 0;

  logic [63:0] rawM;
  logic [63:0] maskM[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_router u0 (
    .clk(clk), .rstN(rstN), .srcPost(srcPost), .srcClear(srcClear),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regSize(regSize), .regWdata(regWdata), .regRdata(regRdata),
    .regErr(regErr), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs applied at negedge, compared at the following negedge
  task automatic step(input logic [63:0] p, input logic [63:0] c, input bit v,
                      input bit w, input logic [11:0] a, input logic [1:0] sz,
                      input logic [63:0] wd, input string tag);
    int idx;
    bit bad;
    logic [63:0] expRd;
    logic [3:0] expIrq;
    srcPost = p; srcClear = c; regValid = v; regWrite = w;
    regAddr = a; regSize = sz; regWdata = wd;
    idx = int'(a) / 64;
    bad = 0;
    expRd = '0;
    if (v) begin
      if (sz != 2'd3) bad = 1;
      else if (idx == 0) begin
        if (w) bad = 1; else expRd = rawM;
      end else if (idx <= 4) begin
        if (!w) expRd = maskM[idx-1];
      end else if (idx <= 8) begin
        if (w) bad = 1; else expRd = maskM[idx-5] & rawM;
      end else bad = 1;
    end
    rawM = (rawM & ~c) | p;
    if (v && w && !bad && idx >= 1 && idx <= 4) maskM[idx-1] = wd;
    for (int k = 0; k < 4; k++) expIrq[k] = |(maskM[k] & rawM);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "regRdata", regRdata, expRd);
    chk(tag, "regErr", {63'd0, regErr}, {63'd0, bad});
    chk(tag, "cpuIrq", {60'd0, cpuIrq}, {60'd0, expIrq});
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step('0, '0, 1, 0, a, 2'd3, '0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [63:0] d, input string tag);
    step('0, '0, 1, 1, a, 2'd3, d, tag);
  endtask
  task automatic ev(input logic [63:0] p, input logic [63:0] c, input string tag);
    step(p, c, 0, 0, '0, 2'd3, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rawM = '0;
    for (int k = 0; k < 4; k++) maskM[k] = '0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet while reset is held
    chk("R10", "cpuIrq in reset", {60'd0, cpuIrq}, 64'd0);
    chk("R10", "regErr in reset", {63'd0, regErr}, 64'd0);
    rstN = 1'b1;
    for (int i = 0; i <= 8; i++) rd(12'(i * 64), "R10");

    // R1: posts set raw bits
    ev(64'h8000_0100_0000_0008, '0, "R1");
    rd(12'h000, "R1");
    // R4 / R5 / R6: masks and effective registers
    wr(12'h040, 64'h0000_0100_0000_0008, "R4");
    wr(12'h0C0, 64'h8000_0000_0000_0000, "R4");
    rd(12'h040, "R4");
    rd(12'h140, "R5");
    rd(12'h1C0, "R5");
    rd(12'h180, "R5");
    // R6: drop sources one by one
    ev('0, 64'h8, "R6");
    rd(12'h140, "R6");
    ev('0, 64'h0000_0100_0000_0000, "R6");
    // R1: clear then read raw
    rd(12'h000, "R1");
    // R2: post and clear together, with mask write on same edge
    wr(12'h080, 64'h20, "R2");
    step(64'h20, 64'h20, 1, 1, 12'h100, 2'd3, 64'h20, "R2");
    rd(12'h000, "R2");
    rd(12'h180, "R2");
    // R3: spurious clear
    ev('0, 64'h400, "R3");
    rd(12'h000, "R3");
    rd(12'h180, "R3");
    // R5: mask write coinciding with a post
    step(64'h4, '0, 1, 1, 12'h040, 2'd3, 64'h4, "R5");
    rd(12'h140, "R5");
    // R7: writes to read-only registers
    wr(12'h000, 64'hFFFF, "R7");
    rd(12'h000, "R7");
    wr(12'h140, 64'hFFFF, "R7");
    rd(12'h140, "R7");
    // R8: narrow sizes
    step('0, '0, 1, 1, 12'h040, 2'd2, 64'hFF, "R8");
    step('0, '0, 1, 0, 12'h040, 2'd0, '0, "R8");
    rd(12'h040, "R8");
    // R9: unmapped indices
    rd(12'h240, "R9");
    wr(12'h500, 64'h1, "R9");
    rd(12'hFC0, "R9");
    // R11: low offset bits ignored
    wr(12'h07F, 64'h0000_0000_0000_0404, "R11");
    rd(12'h0A3, "R11");
    rd(12'h047, "R11");
    // random mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [63:0] p, c, d;
      logic [11:0] a;
      p = ($urandom_range(0, 3) == 0) ? (64'd1 << $urandom_range(0, 63)) : '0;
      c = ($urandom_range(0, 2) == 0) ? (64'd1 << $urandom_range(0, 63)) : '0;
      d = {$urandom, $urandom};
      a = 12'($urandom_range(0, 10) * 64 + $urandom_range(0, 63));
      step(p, c, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
           ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 2)) : 2'd3, d, "R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule